// File: doc/BRIEF.md
# Multi-Channel Edge-Aligned PWM Timer

This block is a timer peripheral that builds several pulse-width-modulated outputs from a single free-running time base. One up-counter runs from zero to a programmable terminal value and then returns to zero, so every channel shares the same period and the same phase. Each channel holds its own compare value and its own output mode. In the reset/set mode, a channel's output rises when the counter restarts and falls when the counter reaches the channel's compare value, which gives a high time equal to that compare value in timer ticks.

Software programs the block through a flat register port: a control word (run mode and a counter clear), the terminal-count (period) word, and a compare word and a mode word for each channel. The counter value can be read back at any time. A clock-enable input stands for the selected timer clock: the counter moves only on cycles where it is high. The usual flow is to set up the period and the channels while the timer is stopped, and then start up-counting.

Top module: `pwm_timer`

## Requirements
- R1: With run field (control bits [1:0]) = 1, the counter steps by one per tick from 0 up to the active period value P and then returns to 0, so one period is P+1 ticks. With any other run value the counter holds.
- R2: The counter changes only on clock cycles where clk_en is high, or when it is cleared.
- R3: Writing the control word with bit 2 set forces the counter to 0 at that clock edge. Bit 2 always reads back as 0.
- R4: A period write made while running takes effect only after the next wrap. While stopped, the written value becomes active at once.
- R5: In mode 7 (reset/set), the output goes high when the counter wraps to 0 and goes low when the counter reaches the channel compare value C, so it is high for C ticks of each period.
- R6: In mode 7, a compare value of 0 keeps the output low, and a compare value greater than P keeps it high.
- R7: In mode 3 (set/reset), the output goes high at the compare match and low at the wrap, so it is high for P+1-C ticks of each period.
- R8: Mode 1 drives the output high, and mode 5 drives it low, at the first compare match after the mode is selected. In both modes the output then holds through later wraps.
- R9: In mode 0 the output follows the manual bit (channel mode-word bit 3) one clock after the write.
- R10: With P = 511, channel 0 compare 384 and channel 1 compare 128 both in mode 7, the two outputs run at the same time with 384 and 128 high ticks out of every 512.
- R11: Register map: 0 control, 1 counter (read-only), 2 period, 4+2k compare of channel k, and 5+2k mode word of channel k (bits [2:0] mode, bit 3 manual bit). Every writable field reads back what was written.
- R12: A compare write takes effect immediately, with no wait for a wrap.
- R13: After reset the timer is stopped, the counter and all registers are 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clk_en | input | 1 | Timer tick qualifier; the counter advances only when high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for both reads and writes |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Combinational read data for reg_addr |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The bench targets the edges of the duty range. A compare value of zero must give a steady low output; a design that lets the wrap-time set win would produce a one-tick glitch every period. A compare value above the period must give a steady high output; a design that compares with "greater or equal" would drop it low. A period rewrite in mid-run must leave the current period at its old length, and a design that switches early would wrap at the new value straight away. The bench also gates clk_en in an alternating pattern and clears the counter while it runs, and it switches a high output into reset mode to confirm that the fall waits for the compare match and then stays low across wraps.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  // register map
  localparam int ADR_CTRL = 0;
  localparam int ADR_CNT  = 1;
  localparam int ADR_PER  = 2;
  localparam int CH_BASE  = 4;

  // control word fields
  localparam int CLR_BIT  = 2;
  localparam logic [1:0] RUN_UP = 2'd1;

  // per-channel output modes
  localparam logic [2:0] OM_MANUAL = 3'd0;
  localparam logic [2:0] OM_SET    = 3'd1;
  localparam logic [2:0] OM_SETRST = 3'd3;
  localparam logic [2:0] OM_RESET  = 3'd5;
  localparam logic [2:0] OM_RSTSET = 3'd7;
endpackage

// File: rtl/pwm_rst_sync.sv
`timescale 1ns/1ps
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             run_up,
  input  logic             clr,
  input  logic [CNT_W-1:0] per_sh,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             tick_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] per_act_q, per_act_d;
  logic             tick;

  assign tick   = run_up & clk_en;
  assign tick_o = tick & ~clr;
  assign wrap_o = tick_o & (cnt_q >= per_act_q);

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr)         cnt_nxt = '0;
    else if (wrap_o) cnt_nxt = '0;
    else if (tick)   cnt_nxt = cnt_q + 1'b1;
  end

  // the period in use changes only at a wrap, or freely while stopped
  always_comb begin
    per_act_d = per_act_q;
    if (!run_up || wrap_o) per_act_d = per_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      per_act_q <= '0;
    end else begin
      cnt_q     <= cnt_nxt;
      per_act_q <= per_act_d;
    end
  end

  assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_up && clk_en && !clr && cnt_q >= per_act_q) |=> (cnt_q == '0));

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_up && clk_en && !clr && cnt_q < per_act_q) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run_up && clk_en) && !clr) |=> $stable(cnt_q));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  assert_period_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_up && !(clk_en && !clr && cnt_q >= per_act_q)) |=> $stable(per_act_q));
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan import pwm_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [2:0]       mode,
  input  logic             man,
  output logic             out_q
);
  logic cmp_evt;
  logic out_d;

  // a match is the tick on which the counter arrives at the compare value
  assign cmp_evt = tick & (cnt_nxt == cmp);

  always_comb begin
    out_d = out_q;
    case (mode)
      OM_MANUAL: out_d = man;
      OM_SET:    if (cmp_evt) out_d = 1'b1;
      OM_SETRST: begin
        if (cmp_evt)   out_d = 1'b1;
        else if (wrap) out_d = 1'b0;
      end
      OM_RESET:  if (cmp_evt) out_d = 1'b0;
      OM_RSTSET: begin
        if (cmp_evt)   out_d = 1'b0;
        else if (wrap) out_d = 1'b1;
      end
      default:   out_d = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assert_rs_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_RSTSET && tick && cnt_nxt == cmp) |=> !out_q);

  assert_rs_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_RSTSET && wrap && cmp != '0) |=> out_q);

  assert_sr_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_SETRST && tick && cnt_nxt == cmp) |=> out_q);

  assert_reset_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_RESET && !out_q) |=> !out_q);

  assert_set_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_SET && out_q) |=> out_q);

  assert_manual_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_MANUAL) |=> (out_q == $past(man)));
endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer import pwm_pkg::*; #(
  parameter  int NCH    = 3,
  parameter  int CNT_W  = 16,
  localparam int ADDR_W = $clog2(CH_BASE + 2 * NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic             rst_ns;
  logic [1:0]       run_q, run_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] cmp_q  [NCH];
  logic [CNT_W-1:0] cmp_d  [NCH];
  logic [2:0]       mode_q [NCH];
  logic [2:0]       mode_d [NCH];
  logic [NCH-1:0]   man_q, man_d;
  logic             clr;
  logic             run_up;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             tick_c, wrap_c;

  pwm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  assign clr    = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL)) && reg_wdata[CLR_BIT];
  assign run_up = (run_q == RUN_UP);

  always_comb begin
    run_d  = run_q;
    per_d  = per_q;
    cmp_d  = cmp_q;
    mode_d = mode_q;
    man_d  = man_q;
    if (reg_wr) begin
      if (reg_addr == ADDR_W'(ADR_CTRL)) run_d = reg_wdata[1:0];
      if (reg_addr == ADDR_W'(ADR_PER))  per_d = reg_wdata;
      for (int k = 0; k < NCH; k++) begin
        if (reg_addr == ADDR_W'(CH_BASE + 2 * k)) cmp_d[k] = reg_wdata;
        if (reg_addr == ADDR_W'(CH_BASE + 2 * k + 1)) begin
          mode_d[k] = reg_wdata[2:0];
          man_d[k]  = reg_wdata[3];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      run_q <= '0;
      per_q <= '0;
      man_q <= '0;
      for (int k = 0; k < NCH; k++) begin
        cmp_q[k]  <= '0;
        mode_q[k] <= '0;
      end
    end else begin
      run_q  <= run_d;
      per_q  <= per_d;
      cmp_q  <= cmp_d;
      mode_q <= mode_d;
      man_q  <= man_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADR_CTRL)) reg_rdata = CNT_W'(run_q);
    if (reg_addr == ADDR_W'(ADR_CNT))  reg_rdata = cnt_q;
    if (reg_addr == ADDR_W'(ADR_PER))  reg_rdata = per_q;
    for (int k = 0; k < NCH; k++) begin
      if (reg_addr == ADDR_W'(CH_BASE + 2 * k))     reg_rdata = cmp_q[k];
      if (reg_addr == ADDR_W'(CH_BASE + 2 * k + 1)) reg_rdata = CNT_W'({man_q[k], mode_q[k]});
    end
  end

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_ns),
    .clk_en  (clk_en),
    .run_up  (run_up),
    .clr     (clr),
    .per_sh  (per_q),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .tick_o  (tick_c),
    .wrap_o  (wrap_c)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_ns),
      .tick    (tick_c),
      .wrap    (wrap_c),
      .cnt_nxt (cnt_nxt),
      .cmp     (cmp_q[g]),
      .mode    (mode_q[g]),
      .man     (man_q[g]),
      .out_q   (pwm_out[g])
    );
  end

  assert_reset_state_R13: assert property (@(posedge clk)
    !rst_ns |=> (pwm_out == '0 && cnt_q == '0));
endmodule

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
module sim_pwm_timer;
  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam int AW  = $clog2(4 + 2 * NCH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [CW-1:0] reg_wdata;
  logic [CW-1:0] reg_rdata;
  logic [NCH-1:0] pwm_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwm_timer #(.NCH(NCH), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out)
  );

  // reference model built from the requirements; pushes expected outputs
  int       m_cnt, m_pact, m_psh, m_run;
  int       m_cmp  [NCH];
  bit [2:0] m_mode [NCH];
  bit       m_man  [NCH];
  bit [NCH-1:0] m_out;
  bit [NCH-1:0] exp_q [$];
  bit m_clr, m_tk, m_wr, m_ev;
  int m_nx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pact = 0; m_psh = 0; m_run = 0; m_out = '0;
      for (int k = 0; k < NCH; k++) begin m_cmp[k] = 0; m_mode[k] = 0; m_man[k] = 0; end
      exp_q.delete();
    end else begin
      m_clr = reg_wr && reg_addr == 0 && reg_wdata[2];
      m_tk  = (m_run == 1) && clk_en;
      m_wr  = m_tk && !m_clr && (m_cnt >= m_pact);
      m_nx  = m_clr ? 0 : (m_tk ? (m_wr ? 0 : m_cnt + 1) : m_cnt);
      for (int k = 0; k < NCH; k++) begin
        m_ev = m_tk && !m_clr && (m_nx == m_cmp[k]);
        case (m_mode[k])
          3'd0: m_out[k] = m_man[k];
          3'd1: if (m_ev) m_out[k] = 1'b1;
          3'd3: if (m_ev) m_out[k] = 1'b1; else if (m_wr) m_out[k] = 1'b0;
          3'd5: if (m_ev) m_out[k] = 1'b0;
          3'd7: if (m_ev) m_out[k] = 1'b0; else if (m_wr) m_out[k] = 1'b1;
          default: ;
        endcase
      end
      if (m_run != 1 || m_wr) m_pact = m_psh;
      m_cnt = m_nx;
      if (reg_wr) begin
        if (reg_addr == 0) m_run = int'(reg_wdata[1:0]);
        if (reg_addr == 2) m_psh = int'(reg_wdata);
        for (int k = 0; k < NCH; k++) begin
          if (int'(reg_addr) == 4 + 2 * k) m_cmp[k] = int'(reg_wdata);
          if (int'(reg_addr) == 5 + 2 * k) begin
            m_mode[k] = reg_wdata[2:0];
            m_man[k]  = reg_wdata[3];
          end
        end
      end
      exp_q.push_back(m_out);
    end
  end

  // monitor: pops one expected vector per cycle and compares it
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit [NCH-1:0] e;
      e = exp_q.pop_front();
      n_chk++;
      if (pwm_out !== e) begin
        n_fail++;
        if (n_fail < 20)
          $display("FAIL R10 output vector t=%0t actual=%b expected=%b", $time, pwm_out, e);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = CW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n, output int h0, output int h1, output int h2);
    h0 = 0; h1 = 0; h2 = 0;
    repeat (n) begin
      @(negedge clk);
      #2;
      if (pwm_out[0]) h0++;
      if (pwm_out[1]) h1++;
      if (pwm_out[2]) h2++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, c0, h0, h1, h2, mx, prev;
    rst_n = 1'b0; clk_en = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(3);

    // R13 reset state
    chk("R13 outputs", int'(pwm_out), 0);
    rd(0, v); chk("R13 control", v, 0);
    rd(1, v); chk("R13 counter", v, 0);
    rd(2, v); chk("R13 period", v, 0);

    // R11 configure while stopped, read back
    wr(2, 511);
    wr(4, 384); wr(5, 7);
    wr(6, 128); wr(7, 7);
    wr(9, 7);
    rd(2, v); chk("R11 period", v, 511);
    rd(4, v); chk("R11 cmp0", v, 384);
    rd(6, v); chk("R11 cmp1", v, 128);
    rd(7, v); chk("R11 mode1", v, 7);

    // R1 stopped counter holds even with ticks
    clk_en = 1'b1;
    idle(20);
    rd(1, v); chk("R1 stopped", v, 0);

    // R10 / R5 / R6 two duties at once, channel 2 compare zero
    wr(0, 1);
    idle(600);
    measure(512, h0, h1, h2);
    chk("R10 ch0 high ticks", h0, 384);
    chk("R5 ch1 high ticks", h1, 128);
    chk("R6 compare zero low", h2, 0);

    // R2 gated ticks
    clk_en = 1'b0;
    rd(1, c0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      clk_en = i[0];
    end
    @(negedge clk);
    clk_en = 1'b0;
    rd(1, v); chk("R2 four ticks", v, (c0 + 4) % 512);
    clk_en = 1'b1;

    // R12 immediate compare change, R6 compare above period
    wr(4, 256);
    wr(8, 600);
    idle(520);
    measure(512, h0, h1, h2);
    chk("R12 new compare", h0, 256);
    chk("R6 compare above period high", h2, 512);

    // R7 set/reset mode
    wr(7, 3);
    idle(520);
    measure(512, h0, h1, h2);
    chk("R7 set/reset high ticks", h1, 384);

    // R9 manual mode
    wr(9, 8);
    idle(1); #2;
    chk("R9 manual high", int'(pwm_out[2]), 1);
    wr(9, 0);
    idle(1); #2;
    chk("R9 manual low", int'(pwm_out[2]), 0);

    // R8 reset mode from high, then set mode
    wr(9, 8);
    wr(8, 50);
    wr(9, 5);
    idle(1); #2;
    chk("R8 reset waits for match", int'(pwm_out[2]), 1);
    idle(1100);
    measure(512, h0, h1, h2);
    chk("R8 reset holds low", h2, 0);
    wr(9, 1);
    idle(600);
    measure(512, h0, h1, h2);
    chk("R8 set holds high", h2, 512);

    // R3 clear while running
    clk_en = 1'b0;
    idle(2);
    wr(0, 5);
    rd(1, v); chk("R3 counter cleared", v, 0);
    rd(0, v); chk("R3 clear reads zero", v, 1);

    // R4 period rewrite while running waits for wrap
    wr(2, 255);
    clk_en = 1'b1;
    mx = 0; prev = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(1, v);
      if (v < prev) break;
      if (v > mx) mx = v;
      prev = v;
    end
    chk("R4 old period kept", mx, 511);
    mx = 0; prev = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(1, v);
      if (v < prev) break;
      if (v > mx) mx = v;
      prev = v;
    end
    chk("R4 new period used", mx, 255);

    idle(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule